// File: doc/BRIEF.md
# Four-Stage Pipelined Integer Multiplier

This block multiplies two unsigned 32-bit integers and returns the low 32 bits of the product. It is fully pipelined: a new operand pair may be issued on every clock, and each issue carries a 6-bit destination register tag. The work is spread over four register stages. Each stage folds the partial products of one 8-bit digit of the multiplier into a running sum. Every result leaves the pipe a fixed number of cycles after issue.

There is no interlock and no stall. A statically scheduled program counts the cycles itself and plans the write-back slot of each result. The tag travels alongside the data, so the write port knows which register to update at the moment the result appears. A cycle with no issue becomes a bubble: its valid bit is low all the way through.

Top module: `mul32_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, every stage valid bit is cleared. `res_vld` is low in the cycle after any such edge.
- R2: For a valid issue, `res_prod` equals (`iss_a` × `iss_b`) mod 2^32, with both operands treated as unsigned.
- R3: Operands presented at rising edge k show on the outputs after edge k+3, and stay there until edge k+4. The result is therefore visible four sampling points after the one at which it was driven, and the latency never varies.
- R4: Issues on consecutive cycles produce results on consecutive cycles. No result depends on its neighbours.
- R5: A cycle with `iss_vld` low gives `res_vld` low exactly four cycles later. Operand and tag values driven during such a bubble do not alter any valid result.
- R6: `res_tag` equals the `iss_tag` that was presented with the same issue.
- R7: Product bits at and above bit 32 are discarded. For example, 0xFFFFFFFF × 0xFFFFFFFF yields 0x00000001.
- R8: Operations still in flight when reset is applied never emerge as valid results. Issues made after reset is released complete normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | 1 | An operation is issued this cycle |
| iss_a | input | 32 | Multiplicand, unsigned |
| iss_b | input | 32 | Multiplier, unsigned |
| iss_tag | input | 6 | Destination register tag of the issue |
| res_vld | output | 1 | A result is present |
| res_prod | output | 32 | Low 32 bits of the product |
| res_tag | output | 6 | Destination tag of the result |

## Verification
The bench walks a single set bit through every position of the multiplier against several multiplicands. A stage that used the wrong digit slice, or shifted a partial product by the wrong amount, would give a wrong power-of-two multiple of the multiplicand. Full-digit and all-ones operands test the carry and the wrap past bit 31: a design that kept the high bits or dropped an inner carry would miscompare there. Bubbles loaded with garbage operands, and a reset asserted while three operations are in flight, expose a valid bit that lags or leads its data, or stale work that survives reset. Every output is compared exactly four cycles after issue, so a stage too many or too few shows up at once.

// File: rtl/mulp_pkg.sv
// Shared types for the pipelined multiplier.
// Assumes: a single tag width serves every instance in the chip.
package mulp_pkg;
    localparam int unsigned TAG_BITS = 6;

    typedef logic [TAG_BITS-1:0] tag_t;

    // Control word that travels with every operation through the pipe
    typedef struct packed {
        logic vld;
        tag_t tag;
    } ctl_t;
endpackage

// File: rtl/mulp_digit_sum.sv
// Sums the partial products of one multiplier digit, already shifted to
// the digit's weight and truncated to WIDTH bits.
// Assumes: SHIFT is the bit weight of the digit's least significant bit.
module mulp_digit_sum #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DIGIT = 8,
    parameter int unsigned SHIFT = 0
) (
    input  logic [WIDTH-1:0] mcand,
    input  logic [DIGIT-1:0] digit,
    output logic [WIDTH-1:0] sum
);
    logic [WIDTH-1:0] chain [0:DIGIT];

    assign chain[0] = '0;

    // One adder per multiplier bit, each adding the shifted multiplicand
    for (genvar j = 0; j < DIGIT; j++) begin : g_bit
        assign chain[j+1] = chain[j] + (digit[j] ? (mcand << (SHIFT + j)) : '0);
    end

    assign sum = chain[DIGIT];
endmodule

// File: rtl/mulp_stage.sv
// One pipeline stage: adds the partial products of the lowest remaining
// multiplier digit to the running sum, then registers the sum, the
// operands (multiplier shifted down one digit) and the control word.
// Assumes: IDX counts stages from zero; reset clears the valid bit only.
module mulp_stage
    import mulp_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DIGIT = 8,
    parameter int unsigned IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             in_ctl,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_acc,
    output ctl_t             out_ctl,
    output logic [WIDTH-1:0] out_a,
    output logic [WIDTH-1:0] out_b,
    output logic [WIDTH-1:0] out_acc
);
    localparam int unsigned SHIFT = IDX * DIGIT;

    logic [WIDTH-1:0] part;

    mulp_digit_sum #(
        .WIDTH(WIDTH),
        .DIGIT(DIGIT),
        .SHIFT(SHIFT)
    ) digit_i (
        .mcand(in_a),
        .digit(in_b[DIGIT-1:0]),
        .sum  (part)
    );

    // Control register: valid cleared by reset, tag follows the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ctl.vld <= 1'b0;
        end else begin
            out_ctl.vld <= in_ctl.vld;
        end
        out_ctl.tag <= in_ctl.tag;
    end

    // Data registers: running sum and the operands for the next stage
    always_ff @(posedge clk) begin
        out_acc <= in_acc + part;
        out_a   <= in_a;
        out_b   <= in_b >> DIGIT;
    end
endmodule

// File: rtl/mul32_pipe.sv
// Fully pipelined unsigned multiplier returning the low WIDTH bits.
// WIDTH/DIGIT stages, each consuming DIGIT multiplier bits; one issue
// per cycle, fixed latency, no stall. The tag rides with each operation.
// Assumes: WIDTH is a multiple of DIGIT.
module mul32_pipe
    import mulp_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DIGIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_vld,
    input  logic [WIDTH-1:0]    iss_a,
    input  logic [WIDTH-1:0]    iss_b,
    input  logic [TAG_BITS-1:0] iss_tag,
    output logic                res_vld,
    output logic [WIDTH-1:0]    res_prod,
    output logic [TAG_BITS-1:0] res_tag
);
    localparam int unsigned STAGES = WIDTH / DIGIT;

    ctl_t             ctl_p [0:STAGES];
    logic [WIDTH-1:0] a_p   [0:STAGES];
    logic [WIDTH-1:0] b_p   [0:STAGES];
    logic [WIDTH-1:0] acc_p [0:STAGES];

    // Issue side of the chain
    assign ctl_p[0] = '{vld: iss_vld, tag: iss_tag};
    assign a_p[0]   = iss_a;
    assign b_p[0]   = iss_b;
    assign acc_p[0] = '0;

    // One stage per multiplier digit
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        mulp_stage #(
            .WIDTH(WIDTH),
            .DIGIT(DIGIT),
            .IDX  (s)
        ) stage_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_ctl (ctl_p[s]),
            .in_a   (a_p[s]),
            .in_b   (b_p[s]),
            .in_acc (acc_p[s]),
            .out_ctl(ctl_p[s+1]),
            .out_a  (a_p[s+1]),
            .out_b  (b_p[s+1]),
            .out_acc(acc_p[s+1])
        );
    end

    // Result side of the chain
    assign res_vld  = ctl_p[STAGES].vld;
    assign res_tag  = ctl_p[STAGES].tag;
    assign res_prod = acc_p[STAGES];
endmodule

// File: rtl/mul32_pipe_chk.sv
// Checker for mul32_pipe: an independent delay-line model of issue
// (valid, tag, product) compared with the results at the output.
// Assumes: bound into every mul32_pipe instance.
module mul32_pipe_chk
    import mulp_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DIGIT = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                iss_vld,
    input logic [WIDTH-1:0]    iss_a,
    input logic [WIDTH-1:0]    iss_b,
    input logic [TAG_BITS-1:0] iss_tag,
    input logic                res_vld,
    input logic [WIDTH-1:0]    res_prod,
    input logic [TAG_BITS-1:0] res_tag
);
    localparam int unsigned STAGES = WIDTH / DIGIT;

    logic                m_vld  [0:STAGES-1];
    logic [TAG_BITS-1:0] m_tag  [0:STAGES-1];
    logic [WIDTH-1:0]    m_prod [0:STAGES-1];

    // Reference delay line with one slot per pipeline stage
    always_ff @(posedge clk) begin
        m_vld[0]  <= rst_n ? iss_vld : 1'b0;
        m_tag[0]  <= iss_tag;
        m_prod[0] <= WIDTH'(iss_a * iss_b);
        for (int i = 1; i < STAGES; i++) begin
            m_vld[i]  <= rst_n ? m_vld[i-1] : 1'b0;
            m_tag[i]  <= m_tag[i-1];
            m_prod[i] <= m_prod[i-1];
        end
    end

    // R1: reset leaves no valid result
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !res_vld);

    // R3, R5, R8: valid appears exactly STAGES cycles after a valid issue
    a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_vld == m_vld[STAGES-1]));

    // R2, R7: low product of the matching issue
    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_prod == m_prod[STAGES-1]));

    // R6: tag of the matching issue
    a_r6_tag_follows: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_tag == m_tag[STAGES-1]));
endmodule

bind mul32_pipe mul32_pipe_chk #(.WIDTH(WIDTH), .DIGIT(DIGIT)) chk_i (.*);

// File: tb/mul32_pipe_tb_top.sv
`timescale 1ns/1ps
// Bench for mul32_pipe: directed sweeps plus random streams, each output
// compared at the fourth sampling point after its issue.
module mul32_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_vld = 1'b0;
    logic [31:0] iss_a = '0;
    logic [31:0] iss_b = '0;
    logic [5:0]  iss_tag = '0;
    logic        res_vld;
    logic [31:0] res_prod;
    logic [5:0]  res_tag;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    string vld_req = "R1";
    string prod_req = "R2";

    // Expected values for the last four drives; index 3 is the oldest
    logic        h_vld  [0:3];
    logic [31:0] h_prod [0:3];
    logic [5:0]  h_tag  [0:3];

    mul32_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_a(iss_a),
        .iss_b(iss_b), .iss_tag(iss_tag), .res_vld(res_vld),
        .res_prod(res_prod), .res_tag(res_tag)
    );

    always #4 clk = ~clk;

    // Compare outputs with the oldest entry, then push a new drive
    task automatic step(input logic v, input logic [31:0] a,
                        input logic [31:0] b, input logic [5:0] t,
                        input logic rst_next);
        @(negedge clk);
        vectors++;
        if (res_vld !== h_vld[3]) begin
            fails++;
            $display("FAIL %s valid: actual=%b expected=%b", vld_req, res_vld, h_vld[3]);
        end else if (h_vld[3]) begin
            if (res_prod !== h_prod[3]) begin
                fails++;
                $display("FAIL %s product: actual=%h expected=%h", prod_req, res_prod, h_prod[3]);
            end
            if (res_tag !== h_tag[3]) begin
                fails++;
                $display("FAIL R6 tag: actual=%0d expected=%0d", res_tag, h_tag[3]);
            end
        end
        for (int i = 3; i > 0; i--) begin
            h_vld[i]  = rst_next ? 1'b0 : h_vld[i-1];
            h_prod[i] = h_prod[i-1];
            h_tag[i]  = h_tag[i-1];
        end
        h_vld[0]  = v && !rst_next;
        h_prod[0] = a * b;
        h_tag[0]  = t;
        rst_n   = !rst_next;
        iss_vld = v;
        iss_a   = a;
        iss_b   = b;
        iss_tag = t;
    endtask

    initial begin
        logic [31:0] mc [0:7];
        for (int i = 0; i < 4; i++) begin
            h_vld[i] = 1'b0; h_prod[i] = '0; h_tag[i] = '0;
        end
        mc[0] = 32'h0;        mc[1] = 32'h1;        mc[2] = 32'hFFFF_FFFF;
        mc[3] = 32'h8000_0000; mc[4] = 32'h1234_5678; mc[5] = 32'hA5A5_A5A5;
        mc[6] = 32'h0000_00FF; mc[7] = 32'hDEAD_BEEF;

        // R1: reset held with garbage valid issues; no result may appear
        vld_req = "R1";
        for (int n = 0; n < 6; n++) step(1'b1, $urandom, $urandom, 6'(n), 1'b1);
        for (int n = 0; n < 4; n++) step(1'b0, $urandom, $urandom, 6'(n), 1'b0);

        // R2, R3, R4: one-hot multiplier through every digit, back to back
        vld_req = "R3"; prod_req = "R2";
        for (int m = 0; m < 8; m++)
            for (int k = 0; k < 32; k++)
                step(1'b1, mc[m], 32'h1 << k, 6'(m * 32 + k), 1'b0);

        // R2: full digits at each stage position, and digit pairs
        for (int m = 0; m < 8; m++)
            for (int d = 0; d < 4; d++) begin
                step(1'b1, mc[m], 32'hFF << (8 * d), 6'(d + 4 * m), 1'b0);
                step(1'b1, mc[m], 32'h81 << (8 * d), 6'(63 - d), 1'b0);
            end

        // R7: wrap past bit 31 discarded
        prod_req = "R7";
        step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd1, 1'b0);
        step(1'b1, 32'h0001_0000, 32'h0001_0000, 6'd2, 1'b0);
        step(1'b1, 32'h8000_0001, 32'h0000_0002, 6'd3, 1'b0);
        step(1'b1, 32'hFFFF_FFFF, 32'h0000_0002, 6'd4, 1'b0);
        for (int n = 0; n < 64; n++) step(1'b1, $urandom | 32'hF000_0000,
                                          $urandom | 32'hF000_0000, 6'(n), 1'b0);

        // R5: bubbles every third cycle, loaded with garbage operands
        vld_req = "R5"; prod_req = "R2";
        for (int n = 0; n < 600; n++)
            step((n % 3) != 0, $urandom, $urandom, 6'($urandom), 1'b0);

        // R4: long random back-to-back stream
        vld_req = "R4";
        for (int n = 0; n < 3000; n++)
            step(1'b1, $urandom, $urandom, 6'($urandom), 1'b0);

        // R8: three issues in flight, reset for one cycle, then resume
        vld_req = "R8";
        for (int r = 0; r < 5; r++) begin
            step(1'b1, $urandom, $urandom, 6'd10, 1'b0);
            step(1'b1, $urandom, $urandom, 6'd11, 1'b0);
            step(1'b1, $urandom, $urandom, 6'd12, 1'b0);
            step(1'b1, $urandom, $urandom, 6'd13, 1'b1);
            for (int n = 0; n < 6; n++)
                step(1'b1, $urandom, $urandom, 6'(20 + n), 1'b0);
        end

        // Drain the pipe with bubbles
        for (int n = 0; n < 6; n++) step(1'b0, '0, '0, '0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failed R4 check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule